// File: doc/BRIEF.md
# Self-Timed Flash Programming Sequencer

This block sequences the programming mode of a 4K-byte on-chip code array. A host presents an address, a data byte and a three-bit operation code, and uses an active-low program strobe to launch work. The end of a strobe pulse starts a self-timed byte write or a lock-bit write. The write then runs for a fixed number of clock cycles with no further help from the host. Holding the strobe low for a long interval with the erase code selected wipes the whole array. Verify reads and signature reads need no strobe: the host selects the read code and the result appears one cycle later.

While a self-timed write is running, the host can track progress in two ways. The first is a ready/busy output. The second is data polling: reading the address being written returns the inverted value of bit 7 of that datum until the write completes. Programming can only clear bits, so a byte that is not blank must be erased before it can take a new value. When two particular lock bits are programmed, verify reads are blocked. The cell array itself sits outside the block, behind a simple synchronous memory port.

Top module: `flashProgSeq`

## Requirements
- R1: A byte write begins when progN returns high after being low, provided mode = 1 at that edge. Once the write completes, a verify read returns the stored byte on dataOut in the cycle after the request. A verify read is mode = 4, with the address held for one cycle.
- R2: A write lasts exactly WRITE_CYCLES clock cycles. The array is updated in the last of those cycles.
- R3: While a byte write is busy, a verify read of the address being written returns {~d[7], d[6:0]}, where d is the data byte given with the strobe. After the write ends, the same read returns the true stored byte.
- R4: rdyBusy is high out of reset. It goes low in the cycle after an accepted strobe rise, stays low for WRITE_CYCLES cycles, and then returns high.
- R5: With mode = 3, holding progN low for ERASE_CYCLES consecutive idle cycles sets every array byte to FFh and clears all lock bits. This happens once per hold. A shorter hold has no effect.
- R6: A byte write stores old AND data. A bit that is already 0 stays 0 until the array is erased.
- R7: progErr goes high after a byte write whose data has a 1 where the old byte holds 0. It is cleared when the next write is accepted, and it is 0 after reset.
- R8: With mode = 2 and dataIn[1:0] = n (1 to 3), a self-timed write programs lock bit n. Once lock bits 1 and 2 are both programmed, every verify read returns FFh.
- R9: A signature read (mode = 5) returns 1Eh at address 030h and 51h at 031h. At 032h it returns FFh when HIGH_VOLT = 1 and 05h otherwise. Every other address returns FFh. Lock bits have no effect on signature reads.
- R10: A strobe rise that arrives while a write is busy is ignored. It also sets cmdDropped, which stays high until reset.
- R11: When mode is neither 4 nor 5, dataOut shows FFh in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for writes and reads |
| dataIn | input | 8 | Write data; bits 1:0 select the lock bit for a lock write |
| mode | input | 3 | Operation code: 0 idle, 1 byte write, 2 lock write, 3 erase, 4 verify, 5 signature |
| progN | input | 1 | Active-low program strobe |
| dataOut | output | 8 | Read result, one cycle after the request |
| rdyBusy | output | 1 | High when ready, low while a write runs |
| progErr | output | 1 | The last byte write tried to set a cleared bit |
| cmdDropped | output | 1 | Sticky flag: a strobe arrived while busy |
| memAddr | output | ADDR_W | Array port address |
| memRd | output | 1 | Array read enable (data is returned the next cycle) |
| memWe | output | 1 | Array write enable |
| memWrData | output | 8 | Array write data |
| memRdData | input | 8 | Array read data |
| memErase | output | 1 | One-cycle pulse that sets the whole array to FFh |

## Verification
Writes are tried in three ways: onto a blank byte, onto a byte that already holds data with bits the new value would need to set, and with the same value again. The first case separates a true store from an AND merge. The second and third show whether progErr tracks only the conflicting bits. Polling reads during busy, compared with reads after completion, show whether the inverted bit 7 is tied to the busy window. A second strobe during busy, followed by a read of its target address, shows that the strobe was actually dropped and not only flagged. An erase hold one cycle too short, set against a full hold, pins the exact erase threshold. Lock writes are checked one bit at a time, so that the block is confirmed to need both bits before it blocks reads.

// File: rtl/flashProgPkg.sv
package flashProgPkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_BYTE   = 3'd1,
    MODE_LOCK   = 3'd2,
    MODE_ERASE  = 3'd3,
    MODE_VERIFY = 3'd4,
    MODE_SIG    = 3'd5
  } progMode_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_VERIFY,
    RD_SIG,
    RD_BLOCKED
  } rdKind_e;

  typedef enum logic [1:0] {
    OUT_CONST,
    OUT_MEM,
    OUT_POLL
  } outSel_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic    captureCmd;  // strobe accepted: latch address and data
    logic    fetchOld;    // read the old byte from the array
    logic    captureOld;  // old byte is on memRdData
    logic    commitByte;  // last busy cycle of a byte write
    logic    byteBusy;    // a byte write is in progress
    rdKind_e rdKind;      // read requested this cycle
  } ctrlStrobes_t;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/flashProgCtrl.sv
module flashProgCtrl
  import flashProgPkg::*;
#(
  parameter int WRITE_CYCLES = 18000,
  parameter int ERASE_CYCLES = 120000,
  parameter int LOCK_BITS    = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   mode,
  input  logic         progN,
  input  logic [1:0]   lockSel,
  output ctrlStrobes_t st,
  output logic         rdyBusy,
  output logic         cmdDropped,
  output logic         memErase
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam int EW = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT  = CW'(WRITE_CYCLES - 1);
  localparam logic [EW-1:0] ERASE_MAX = EW'(ERASE_CYCLES - 1);

  progMode_e modeE;
  logic progQ, busy, isByte, dropped, eraseDone;
  logic [CW-1:0] cnt;
  logic [EW-1:0] eraseCnt;
  logic [1:0] pendSel;
  logic [LOCK_BITS-1:0] lockBits;
  logic rise, accept, lastCycle, eraseHold, eraseFire, readBlocked;

  assign modeE       = progMode_e'(mode);
  assign rise        = progN & ~progQ;
  assign accept      = rise & ~busy & (modeE == MODE_BYTE || modeE == MODE_LOCK);
  assign lastCycle   = busy && (cnt == LAST_CNT);
  assign eraseHold   = (modeE == MODE_ERASE) & ~progN & ~busy;
  assign eraseFire   = eraseHold & ~eraseDone & (eraseCnt == ERASE_MAX);
  assign readBlocked = lockBits[0] & lockBits[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progQ     <= 1'b1;
      busy      <= 1'b0;
      isByte    <= 1'b0;
      cnt       <= '0;
      pendSel   <= '0;
      dropped   <= 1'b0;
      eraseCnt  <= '0;
      eraseDone <= 1'b0;
      lockBits  <= '0;
    end else begin
      progQ <= progN;
      if (rise && busy) dropped <= 1'b1;
      if (accept) begin
        busy    <= 1'b1;
        isByte  <= (modeE == MODE_BYTE);
        pendSel <= lockSel;
        cnt     <= '0;
      end else if (lastCycle) begin
        busy <= 1'b0;
        if (!isByte && pendSel != 2'd0 && int'(pendSel) <= LOCK_BITS)
          lockBits[pendSel - 2'd1] <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (eraseHold) begin
        if (eraseCnt != ERASE_MAX) eraseCnt <= eraseCnt + 1'b1;
      end else begin
        eraseCnt <= '0;
      end
      if (eraseFire) begin
        eraseDone <= 1'b1;
        lockBits  <= '0;
      end else if (progN) begin
        eraseDone <= 1'b0;
      end
    end
  end

  always_comb begin
    st.captureCmd = accept;
    st.fetchOld   = busy & isByte & (cnt == '0);
    st.captureOld = busy & isByte & (cnt == CW'(1));
    st.commitByte = lastCycle & isByte;
    st.byteBusy   = busy & isByte;
    unique case (modeE)
      MODE_VERIFY: st.rdKind = readBlocked ? RD_BLOCKED : RD_VERIFY;
      MODE_SIG:    st.rdKind = RD_SIG;
      default:     st.rdKind = RD_NONE;
    endcase
  end

  assign rdyBusy    = ~busy;
  assign cmdDropped = dropped;
  assign memErase   = eraseFire;

  // R2: ready again right after the commit cycle
  assert_commit_then_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.commitByte |=> rdyBusy);
  // R4: busy only begins after a strobe rise
  assert_busy_after_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBusy) |-> ($past(progN) && !$past(progQ)));
  // R10: no command is accepted while busy
  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdyBusy |-> !st.captureCmd);
  // R10: the dropped flag is sticky
  assert_dropped_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdDropped |=> cmdDropped);
  // R5: erase only fires while idle
  assert_erase_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    memErase |-> rdyBusy);

endmodule

// File: rtl/flashProgData.sv
module flashProgData
  import flashProgPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  ctrlStrobes_t      st,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWe,
  output logic [7:0]        memWrData,
  output logic [7:0]        dataOut,
  output logic              progErr
);

  localparam logic [7:0] SIG_VOLT = HIGH_VOLT ? 8'hFF : 8'h05;

  logic [ADDR_W-1:0] pendAddr;
  logic [7:0] wrData, newByte, constQ, sigVal;
  logic errQ, pollHit, verifyReq;
  outSel_e outSelQ, outSelD;
  logic [7:0] constD;

  assign pollHit   = st.byteBusy && (addr == pendAddr);
  assign verifyReq = (st.rdKind == RD_VERIFY) || (st.rdKind == RD_BLOCKED);

  always_comb begin
    if (addr == ADDR_W'('h30))      sigVal = 8'h1E;
    else if (addr == ADDR_W'('h31)) sigVal = 8'h51;
    else if (addr == ADDR_W'('h32)) sigVal = SIG_VOLT;
    else                            sigVal = BLANK_BYTE;
  end

  always_comb begin
    outSelD = OUT_CONST;
    constD  = BLANK_BYTE;
    if (verifyReq && pollHit)       outSelD = OUT_POLL;
    else if (st.rdKind == RD_VERIFY) outSelD = OUT_MEM;
    else if (st.rdKind == RD_SIG)    constD  = sigVal;
  end

  assign memRd     = st.fetchOld | ((st.rdKind == RD_VERIFY) & ~pollHit);
  assign memAddr   = (st.fetchOld | st.commitByte) ? pendAddr : addr;
  assign memWe     = st.commitByte;
  assign memWrData = newByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      wrData   <= BLANK_BYTE;
      newByte  <= BLANK_BYTE;
      errQ     <= 1'b0;
      outSelQ  <= OUT_CONST;
      constQ   <= BLANK_BYTE;
    end else begin
      outSelQ <= outSelD;
      constQ  <= constD;
      if (st.captureCmd) begin
        pendAddr <= addr;
        wrData   <= dataIn;
        errQ     <= 1'b0;
      end else if (st.captureOld) begin
        newByte <= memRdData & wrData;
        errQ    <= |(wrData & ~memRdData);
      end
    end
  end

  always_comb begin
    unique case (outSelQ)
      OUT_MEM:  dataOut = memRdData;
      OUT_POLL: dataOut = {~wrData[7], wrData[6:0]};
      default:  dataOut = constQ;
    endcase
  end

  assign progErr = errQ;

  // R6: a commit never sets a bit the datum leaves clear
  assert_and_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ((memWrData & ~wrData) == 8'h00));
  // R8: a read issued while blocked returns the blank value
  assert_blocked_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdKind == RD_BLOCKED && !pollHit) |=> (dataOut == BLANK_BYTE));
  // R11: no read requested gives FFh
  assert_idle_blank_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdKind == RD_NONE) |=> (dataOut == BLANK_BYTE));

endmodule

// File: rtl/flashProgSeq.sv
module flashProgSeq
  import flashProgPkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 18000,
  parameter int ERASE_CYCLES = 120000,
  parameter bit HIGH_VOLT    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic [2:0]        mode,
  input  logic              progN,
  output logic [7:0]        dataOut,
  output logic              rdyBusy,
  output logic              progErr,
  output logic              cmdDropped,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWe,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              memErase
);

  ctrlStrobes_t st;

  flashProgCtrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .LOCK_BITS   (3)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .progN     (progN),
    .lockSel   (dataIn[1:0]),
    .st        (st),
    .rdyBusy   (rdyBusy),
    .cmdDropped(cmdDropped),
    .memErase  (memErase)
  );

  flashProgData #(
    .ADDR_W   (ADDR_W),
    .HIGH_VOLT(HIGH_VOLT)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .dataIn   (dataIn),
    .st       (st),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memRd    (memRd),
    .memWe    (memWe),
    .memWrData(memWrData),
    .dataOut  (dataOut),
    .progErr  (progErr)
  );

endmodule

// File: tb/flashProgSeq_bench.sv
`timescale 1ns/1ps
module flashProgSeq_bench;

  localparam int AW = 12;
  localparam int WC = 8;
  localparam int EC = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [2:0] mode = 3'd0;
  logic progN = 1'b1;
  logic [7:0] dataOut, memWrData, memRdData;
  logic rdyBusy, progErr, cmdDropped, memRd, memWe, memErase;
  logic [AW-1:0] memAddr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flashProgSeq #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .HIGH_VOLT(1'b1)) u_flashProgSeq (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .mode(mode), .progN(progN),
    .dataOut(dataOut), .rdyBusy(rdyBusy), .progErr(progErr), .cmdDropped(cmdDropped),
    .memAddr(memAddr), .memRd(memRd), .memWe(memWe), .memWrData(memWrData),
    .memRdData(memRdData), .memErase(memErase));

  // array model driven by the block
  logic [7:0] mem [DEPTH];
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    memRdData = 8'hFF;
  end
  always @(posedge clk) begin
    if (memErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (memWe) begin
      mem[memAddr] <= memWrData;
    end
    if (memRd) memRdData <= mem[memAddr];
  end

  // behavioural reference
  logic [7:0] refMem [DEPTH];
  bit refBusy, refIsByte, refErr, refDrop, refPrev, refEraseDone, refOutValid;
  bit [3:1] refLock;
  int refCnt, refEraseCnt;
  logic [AW-1:0] refAddr;
  logic [7:0] refData, refOut;
  logic [1:0] refSel;
  string refTag;

  initial for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;

  always @(posedge clk) begin
    if (!rstN) begin
      refBusy = 0; refIsByte = 0; refErr = 0; refDrop = 0; refPrev = 1;
      refEraseDone = 0; refLock = '0; refCnt = 0; refEraseCnt = 0;
      refOut = 8'hFF; refOutValid = 1; refTag = "R11";
    end else begin
      bit wasBusy, rise;
      wasBusy = refBusy;
      rise = progN && !refPrev;
      refOutValid = 1;
      if (mode == 3'd4) begin
        if (wasBusy && refIsByte && addr == refAddr) begin
          refOut = {~refData[7], refData[6:0]}; refTag = "R3";
        end else if (refLock[1] && refLock[2]) begin
          refOut = 8'hFF; refTag = "R8";
        end else begin
          refOut = refMem[addr]; refTag = "R1";
          refOutValid = !(wasBusy && refIsByte);
        end
      end else if (mode == 3'd5) begin
        refTag = "R9";
        case (addr)
          12'h030: refOut = 8'h1E;
          12'h031: refOut = 8'h51;
          12'h032: refOut = 8'hFF;
          default: refOut = 8'hFF;
        endcase
      end else begin
        refOut = 8'hFF; refTag = "R11";
      end
      if (wasBusy) begin
        refCnt++;
        if (refCnt == WC) begin
          refBusy = 0;
          if (refIsByte) refMem[refAddr] = refMem[refAddr] & refData;
          else if (refSel != 0) refLock[refSel] = 1;
        end
      end
      if (rise && wasBusy) refDrop = 1;
      if (rise && !wasBusy && (mode == 3'd1 || mode == 3'd2)) begin
        refBusy = 1; refCnt = 0; refIsByte = (mode == 3'd1);
        refAddr = addr; refData = dataIn; refSel = dataIn[1:0];
        refErr = (mode == 3'd1) && ((dataIn & ~refMem[addr]) != 0);
      end
      if (mode == 3'd3 && !progN && !wasBusy) begin
        refEraseCnt++;
        if (refEraseCnt == EC && !refEraseDone) begin
          for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
          refLock = '0; refEraseDone = 1;
        end
      end else begin
        refEraseCnt = 0;
      end
      if (progN) refEraseDone = 0;
      refPrev = progN;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R4", {7'd0, rdyBusy}, {7'd0, !refBusy});
      chk("R10", {7'd0, cmdDropped}, {7'd0, refDrop});
      if (refOutValid) chk(refTag, dataOut, refOut);
      if (!refBusy) chk("R7", {7'd0, progErr}, {7'd0, refErr});
    end
  end

  task automatic strobe(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); mode = m; addr = a; dataIn = d; progN = 0;
    @(negedge clk); progN = 1;
    @(negedge clk); mode = 3'd0;
  endtask

  task automatic waitIdle();
    while (!rdyBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readAt(input logic [2:0] m, input logic [AW-1:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk); mode = m; addr = a;
    @(negedge clk); chk(tag, dataOut, exp); mode = 3'd0;
  endtask

  task automatic eraseHold(input int n);
    @(negedge clk); mode = 3'd3; progN = 0;
    repeat (n) @(negedge clk);
    progN = 1;
    @(negedge clk); mode = 3'd0;
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R4", {7'd0, rdyBusy}, 8'd1);
    chk("R10", {7'd0, cmdDropped}, 8'd0);
    chk("R7", {7'd0, progErr}, 8'd0);
    chk("R11", dataOut, 8'hFF);
    rstN = 1;
    @(negedge clk);

    // R1/R3/R4: first write onto blank byte, poll while busy
    @(negedge clk); mode = 3'd1; addr = 12'h123; dataIn = 8'hA5; progN = 0;
    @(negedge clk); progN = 1;
    @(negedge clk); chk("R4", {7'd0, rdyBusy}, 8'd0); mode = 3'd4;
    @(negedge clk); chk("R3", dataOut, 8'h25);
    begin
      int lowCnt = 2;
      mode = 3'd0;
      while (!rdyBusy) begin @(negedge clk); if (!rdyBusy) lowCnt++; end
      chk("R2", 8'(lowCnt), 8'(WC));
    end
    readAt(3'd4, 12'h123, "R1", 8'hA5);

    // R6/R7: conflicting write merges by AND and flags error
    strobe(3'd1, 12'h123, 8'h3C); waitIdle();
    chk("R7", {7'd0, progErr}, 8'd1);
    readAt(3'd4, 12'h123, "R6", 8'h24);
    strobe(3'd1, 12'h123, 8'h24); waitIdle();
    chk("R7", {7'd0, progErr}, 8'd0);

    // R10: strobe during busy is dropped
    strobe(3'd1, 12'h200, 8'h0F);
    strobe(3'd1, 12'h201, 8'h00);
    waitIdle();
    chk("R10", {7'd0, cmdDropped}, 8'd1);
    readAt(3'd4, 12'h201, "R10", 8'hFF);
    readAt(3'd4, 12'h200, "R1", 8'h0F);

    // R9 / R11
    readAt(3'd5, 12'h030, "R9", 8'h1E);
    readAt(3'd5, 12'h031, "R9", 8'h51);
    readAt(3'd5, 12'h032, "R9", 8'hFF);
    readAt(3'd5, 12'h033, "R9", 8'hFF);
    readAt(3'd0, 12'h123, "R11", 8'hFF);

    // R5: one cycle short of the erase threshold
    eraseHold(EC - 1);
    readAt(3'd4, 12'h123, "R5", 8'h24);

    // R8: one lock bit is not enough, two block reads
    strobe(3'd2, 12'h000, 8'h01); waitIdle();
    readAt(3'd4, 12'h123, "R8", 8'h24);
    strobe(3'd2, 12'h000, 8'h02); waitIdle();
    readAt(3'd4, 12'h123, "R8", 8'hFF);
    readAt(3'd5, 12'h030, "R9", 8'h1E);

    // R5: full erase clears array and locks
    eraseHold(EC + 3);
    readAt(3'd4, 12'h123, "R5", 8'hFF);
    readAt(3'd4, 12'h200, "R5", 8'hFF);
    chk("R10", {7'd0, cmdDropped}, 8'd1);

    // R6: rewrite after erase
    strobe(3'd1, 12'h123, 8'h5A); waitIdle();
    readAt(3'd4, 12'h123, "R6", 8'h5A);
    chk("R7", {7'd0, progErr}, 8'd0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule